// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs one vector arithmetic instruction at a time over a small vector register file, one element per clock. Each vector register is a fixed number of bits. A width register selects whether those bits are read as 8-, 16- or 32-bit elements, so the maximum element count grows as the elements get narrower. A run-time length register sets how many elements, counting from element 0, an instruction touches.

The instruction set covers three groups. The setup operations set the width and the length. An element insert loads a register one element at a time. The vector operations are add and subtract, each in a vector-vector form and in a scalar-vector form, plus a not-equal compare. The compare writes a one-bit-per-element flag register. Any add or subtract can name a flag register as a write mask, so that only the flagged elements are written.

Instructions arrive on a valid/ready port. The block reports busy while it steps through elements and pulses done when an instruction completes. A combinational peek port reads any element at the current width, any flag register, the length and the width, so the architectural state can be seen from outside.

Top module: `vec_elem_seq`

## Requirements
- R1: A vector operation reads and writes only elements 0 through VL-1, one element per cycle in rising index order. Destination elements at index VL or above keep their values.
- R2: A set-length instruction (opcode 1) loads VL with the scalar operand, clamped to the current maximum length. A set-width instruction that lowers the maximum below VL clamps VL to the new maximum.
- R3: A set-width instruction (opcode 0) takes the scalar's low 2 bits. Codes 0, 1 and 2 select 8-, 16- and 32-bit elements, and code 3 acts as code 2. The maximum length is REG_BITS divided by the element width (16, 8 or 4 by default). Element i occupies bits [i*w +: w] of its register.
- R4: Vector-vector add (opcode 3) writes vd[i]=va[i]+vb[i], and subtract (opcode 4) writes vd[i]=va[i]-vb[i], both modulo 2^w.
- R5: Scalar-vector add (opcode 5) writes vd[i]=va[i]+s, and subtract (opcode 6) writes vd[i]=va[i]-s. Here s is the low w bits of the scalar operand, applied to every element.
- R6: Compare (opcode 7) sets bit i of flag register fd to (va[i]!=vb[i]) for i<VL. Flag bits at VL or above keep their values. The compare ignores the mask select.
- R7: With in_masked set, an add or subtract writes element i only when bit i of flag register mf is 1. Masked-off elements keep their values.
- R8: in_ready is the inverse of busy. A vector operation with VL=N>0 that is accepted at edge k holds busy high until edge k+N, and done is high for exactly the one cycle after edge k+N. Setup and insert instructions, and vector operations with VL=0, never raise busy and give done in the cycle after acceptance.
- R9: Insert (opcode 2) writes the scalar's low w bits into element in_idx of vd, whatever VL or the mask say. An index at or above the maximum length is ignored.
- R10: After reset the width code is 0, VL is 0, busy and done are low, and every vector and flag register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | 3 | Opcode |
| in_vd | input | RW | Destination vector register |
| in_va | input | RW | First source vector register |
| in_vb | input | RW | Second source vector register |
| in_fd | input | FW | Destination flag register for compare |
| in_mf | input | FW | Flag register used as mask |
| in_masked | input | 1 | Apply the write mask |
| in_idx | input | IDXW | Element index for insert |
| in_scalar | input | 32 | Scalar operand |
| busy | output | 1 | Element sequencing in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Current vector length |
| wsel_out | output | 2 | Current width code |
| pk_reg | input | RW | Peek vector register select |
| pk_idx | input | IDXW | Peek element index |
| pk_flag | input | FW | Peek flag register select |
| pk_elem | output | 32 | Selected element, zero when the index is out of range |
| pk_flags | output | MAXVL | Selected flag register |

## Verification
Setup and insert instructions, and vector operations with VL=0, are due in the cycle after the accepting edge. A vector operation with length N writes its last element on the Nth edge after acceptance, and done rises together with that write. The bench drives at falling edges and counts falling edges from acceptance until done. It requires done at count 1 for the short cases and at count N+1 for vector operations, with busy already high at count 1. Only after done does it compare every element and flag through the combinational peek port with a bit-level model, so each comparison reads state that has settled.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int NVREG    = 4,
  parameter int NFLAG    = 2,
  parameter int REG_BITS = 128,
  localparam int MAXVL = REG_BITS / 8,
  localparam int IDXW  = $clog2(MAXVL),
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int RW    = $clog2(NVREG),
  localparam int FW    = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [RW-1:0]    in_vd,
  input  logic [RW-1:0]    in_va,
  input  logic [RW-1:0]    in_vb,
  input  logic [FW-1:0]    in_fd,
  input  logic [FW-1:0]    in_mf,
  input  logic             in_masked,
  input  logic [IDXW-1:0]  in_idx,
  input  logic [31:0]      in_scalar,
  output logic             busy,
  output logic             done,
  output logic [VLW-1:0]   vl_out,
  output logic [1:0]       wsel_out,
  input  logic [RW-1:0]    pk_reg,
  input  logic [IDXW-1:0]  pk_idx,
  input  logic [FW-1:0]    pk_flag,
  output logic [31:0]      pk_elem,
  output logic [MAXVL-1:0] pk_flags
);

  localparam logic [2:0] OP_SETW  = 3'd0;
  localparam logic [2:0] OP_SETVL = 3'd1;
  localparam logic [2:0] OP_INS   = 3'd2;
  localparam logic [2:0] OP_VADD  = 3'd3;
  localparam logic [2:0] OP_VSUB  = 3'd4;
  localparam logic [2:0] OP_SADD  = 3'd5;
  localparam logic [2:0] OP_SSUB  = 3'd6;
  localparam logic [2:0] OP_CMPNE = 3'd7;

  logic [REG_BITS-1:0] vrf [NVREG];
  logic [MAXVL-1:0]    vfl [NFLAG];

  logic [1:0]      wsel_q;
  logic [VLW-1:0]  vl_q;
  logic            busy_q, done_q;
  logic [2:0]      op_q;
  logic [RW-1:0]   vd_q, va_q, vb_q;
  logic [FW-1:0]   fd_q, mf_q;
  logic            msk_q;
  logic [31:0]     scal_q;
  logic [IDXW-1:0] idx_q;

  function automatic logic [31:0] elem_get(input logic [REG_BITS-1:0] r,
                                           input logic [15:0] s,
                                           input logic [31:0] m);
    logic [REG_BITS-1:0] t;
    t = r >> s;
    return t[31:0] & m;
  endfunction

  function automatic logic [REG_BITS-1:0] elem_put(input logic [REG_BITS-1:0] r,
                                                   input logic [15:0] s,
                                                   input logic [31:0] m,
                                                   input logic [31:0] v);
    logic [REG_BITS-1:0] wm, wv;
    wm = {{(REG_BITS-32){1'b0}}, m} << s;
    wv = {{(REG_BITS-32){1'b0}}, v & m} << s;
    return (r & ~wm) | wv;
  endfunction

  logic [5:0]     ew;
  logic [31:0]    emask;
  logic [VLW-1:0] mvl;
  logic [15:0]    sh;
  logic [31:0]    ea, eb, opb, res;
  logic           lane_en, accept, last_el;
  logic [1:0]     new_ws;
  logic [VLW-1:0] new_mvl;

  assign ew       = 6'd8 << wsel_q;
  assign emask    = (wsel_q == 2'd2) ? 32'hFFFF_FFFF : ((32'd1 << ew) - 32'd1);
  assign mvl      = VLW'(MAXVL >> wsel_q);
  assign sh       = 16'(idx_q) * 16'(ew);
  assign ea       = elem_get(vrf[va_q], sh, emask);
  assign eb       = elem_get(vrf[vb_q], sh, emask);
  assign opb      = (op_q == OP_SADD || op_q == OP_SSUB) ? (scal_q & emask) : eb;
  assign res      = ((op_q == OP_VADD || op_q == OP_SADD) ? ea + opb : ea - opb) & emask;
  assign lane_en  = !msk_q || vfl[mf_q][idx_q];
  assign last_el  = (VLW'(idx_q) + VLW'(1)) == vl_q;
  assign accept   = in_valid && !busy_q;
  assign new_ws   = (in_scalar[1:0] == 2'd3) ? 2'd2 : in_scalar[1:0];
  assign new_mvl  = VLW'(MAXVL >> new_ws);

  assign in_ready = !busy_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign vl_out   = vl_q;
  assign wsel_out = wsel_q;
  assign pk_elem  = (VLW'(pk_idx) < mvl) ? elem_get(vrf[pk_reg], 16'(pk_idx) * 16'(ew), emask) : 32'd0;
  assign pk_flags = vfl[pk_flag];

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel_q <= 2'd0;
      vl_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      fd_q   <= '0;
      mf_q   <= '0;
      msk_q  <= 1'b0;
      scal_q <= '0;
      idx_q  <= '0;
      for (int r = 0; r < NVREG; r++) vrf[r] <= '0;
      for (int f = 0; f < NFLAG; f++) vfl[f] <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (op_q == OP_CMPNE)
          vfl[fd_q][idx_q] <= (ea != eb);
        else if (lane_en)
          vrf[vd_q] <= elem_put(vrf[vd_q], sh, emask, res);
        idx_q <= idx_q + 1'b1;
        if (last_el) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (accept) begin
        op_q   <= in_op;
        vd_q   <= in_vd;
        va_q   <= in_va;
        vb_q   <= in_vb;
        fd_q   <= in_fd;
        mf_q   <= in_mf;
        msk_q  <= in_masked;
        scal_q <= in_scalar;
        idx_q  <= '0;
        case (in_op)
          OP_SETW: begin
            wsel_q <= new_ws;
            if (vl_q > new_mvl) vl_q <= new_mvl;
            done_q <= 1'b1;
          end
          OP_SETVL: begin
            vl_q   <= (in_scalar > 32'(mvl)) ? mvl : VLW'(in_scalar);
            done_q <= 1'b1;
          end
          OP_INS: begin
            if (VLW'(in_idx) < mvl)
              vrf[in_vd] <= elem_put(vrf[in_vd], 16'(in_idx) * 16'(ew), emask, in_scalar);
            done_q <= 1'b1;
          end
          default: begin
            if (vl_q == '0) done_q <= 1'b1;
            else            busy_q <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_VL_BOUND: assert property (@(posedge clk) disable iff (rst)
    vl_q <= mvl); // R2
  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
    wsel_q != 2'd3); // R3
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> VLW'(idx_q) < vl_q); // R1
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> idx_q == $past(idx_q) + 1'b1); // R1
  AST_VL_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(vl_q) && $stable(wsel_q)); // R2
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q); // R8
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !done_q); // R8

endmodule

// File: tb/vec_elem_seq_bench.sv
`timescale 1ns/1ps
module vec_elem_seq_bench;
  localparam int NVREG = 4, NFLAG = 2, REG_BITS = 128;
  localparam int MAXVL = REG_BITS / 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [2:0] in_op = 0;
  logic [1:0] in_vd = 0, in_va = 0, in_vb = 0;
  logic in_fd = 0, in_mf = 0, in_masked = 0;
  logic [3:0] in_idx = 0;
  logic [31:0] in_scalar = 0;
  logic busy, done;
  logic [4:0] vl_out;
  logic [1:0] wsel_out;
  logic [1:0] pk_reg = 0;
  logic [3:0] pk_idx = 0;
  logic pk_flag = 0;
  logic [31:0] pk_elem;
  logic [15:0] pk_flags;

  int checks = 0, errors = 0;
  logic [127:0] mreg [NVREG];
  logic [15:0]  mflg [NFLAG];
  int mvl_len = 0, mws = 0;

  always #4 clk = ~clk;

  vec_elem_seq #(.NVREG(NVREG), .NFLAG(NFLAG), .REG_BITS(REG_BITS)) u_vec_elem_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_vd(in_vd), .in_va(in_va), .in_vb(in_vb), .in_fd(in_fd), .in_mf(in_mf),
    .in_masked(in_masked), .in_idx(in_idx), .in_scalar(in_scalar), .busy(busy),
    .done(done), .vl_out(vl_out), .wsel_out(wsel_out), .pk_reg(pk_reg),
    .pk_idx(pk_idx), .pk_flag(pk_flag), .pk_elem(pk_elem), .pk_flags(pk_flags));

  function automatic int max_len(int ws);
    return MAXVL >> ws;
  endfunction

  function automatic logic [31:0] mget(logic [127:0] r, int i, int ws);
    case (ws)
      0: return {24'd0, r[i*8 +: 8]};
      1: return {16'd0, r[i*16 +: 16]};
      default: return r[i*32 +: 32];
    endcase
  endfunction

  function automatic logic [127:0] mput(logic [127:0] r, int i, int ws, logic [31:0] v);
    logic [127:0] t = r;
    case (ws)
      0: t[i*8 +: 8] = v[7:0];
      1: t[i*16 +: 16] = v[15:0];
      default: t[i*32 +: 32] = v;
    endcase
    return t;
  endfunction

  task automatic model(input int op, int vd, int va, int vb, int fd, int mf, bit m, int idx, logic [31:0] s);
    logic [31:0] a, b, r;
    case (op)
      0: begin
        mws = (s[1:0] == 2'd3) ? 2 : int'(s[1:0]);
        if (mvl_len > max_len(mws)) mvl_len = max_len(mws);
      end
      1: mvl_len = (s > 32'(max_len(mws))) ? max_len(mws) : int'(s);
      2: if (idx < max_len(mws)) mreg[vd] = mput(mreg[vd], idx, mws, s);
      default:
        for (int i = 0; i < mvl_len; i++) begin
          a = mget(mreg[va], i, mws);
          b = (op == 5 || op == 6) ? s : mget(mreg[vb], i, mws);
          if (op == 7) mflg[fd][i] = (a != mget(mreg[vb], i, mws));
          else if (!m || mflg[mf][i]) begin
            r = (op == 3 || op == 5) ? a + b : a - b;
            mreg[vd] = mput(mreg[vd], i, mws, r);
          end
        end
    endcase
  endtask

  task automatic check_state(input string tag);
    bit ok = 1;
    checks++;
    if (vl_out !== 5'(mvl_len) || wsel_out !== 2'(mws)) begin
      ok = 0;
      $display("FAIL %s vl/width actual %0d/%0d expected %0d/%0d", tag, vl_out, wsel_out, mvl_len, mws);
    end
    for (int r = 0; r < NVREG && ok; r++)
      for (int i = 0; i < max_len(mws) && ok; i++) begin
        pk_reg = 2'(r); pk_idx = 4'(i); #0.1;
        if (pk_elem !== mget(mreg[r], i, mws)) begin
          ok = 0;
          $display("FAIL %s reg %0d elem %0d actual %h expected %h", tag, r, i, pk_elem, mget(mreg[r], i, mws));
        end
      end
    for (int f = 0; f < NFLAG && ok; f++) begin
      pk_flag = 1'(f); #0.1;
      if (pk_flags !== mflg[f]) begin
        ok = 0;
        $display("FAIL %s flag %0d actual %h expected %h", tag, f, pk_flags, mflg[f]);
      end
    end
    if (!ok) errors++;
  endtask

  task automatic run(input int op, int vd, int va, int vb, int fd, int mf, bit m, int idx, logic [31:0] s);
    int n = 0, exp_n;
    bit vec = (op >= 3);
    string tag;
    exp_n = (vec && mvl_len > 0) ? mvl_len + 1 : 1;
    case (op)
      0: tag = "R3 R2";
      1: tag = "R2";
      2: tag = "R9";
      3, 4: tag = "R4 R1";
      5, 6: tag = "R5 R1";
      default: tag = "R6";
    endcase
    if (m && op >= 3 && op <= 6) tag = {tag, " R7"};
    @(negedge clk);
    in_op = 3'(op); in_vd = 2'(vd); in_va = 2'(va); in_vb = 2'(vb);
    in_fd = 1'(fd); in_mf = 1'(mf); in_masked = m; in_idx = 4'(idx); in_scalar = s;
    in_valid = 1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        in_valid = 0;
        checks++;
        if (busy !== (exp_n > 1) || in_ready !== !(exp_n > 1)) begin
          errors++;
          $display("FAIL R8 busy/ready actual %b/%b expected %b/%b", busy, in_ready, exp_n > 1, !(exp_n > 1));
        end
      end
      if (done === 1'b1 || n > 40) break;
    end
    checks++;
    if (n != exp_n) begin
      errors++;
      $display("FAIL R8 done cycle actual %0d expected %0d", n, exp_n);
    end
    model(op, vd, va, vb, fd, mf, m, idx, s);
    check_state(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NVREG; r++) mreg[r] = '0;
    for (int f = 0; f < NFLAG; f++) mflg[f] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    checks++;
    if (busy !== 0 || done !== 0 || in_ready !== 1) begin
      errors++;
      $display("FAIL R10 busy/done/ready actual %b/%b/%b expected 0/0/1", busy, done, in_ready);
    end
    check_state("R10");

    run(1, 0, 0, 0, 0, 0, 0, 0, 100);
    for (int i = 0; i < 16; i++) begin
      run(2, 0, 0, 0, 0, 0, 0, i, $urandom);
      run(2, 1, 0, 0, 0, 0, 0, i, (i % 3 == 0) ? 32'd7 : $urandom);
      run(2, 2, 0, 0, 0, 0, 0, i, (i % 3 == 0) ? 32'd7 : $urandom);
    end
    run(3, 3, 0, 1, 0, 0, 0, 0, 0);
    run(1, 0, 0, 0, 0, 0, 0, 0, 5);
    run(4, 3, 1, 0, 0, 0, 0, 0, 0);
    run(1, 0, 0, 0, 0, 0, 0, 0, 0);
    run(3, 3, 0, 1, 0, 0, 0, 0, 0);
    run(7, 0, 0, 1, 1, 0, 0, 0, 0);
    run(1, 0, 0, 0, 0, 0, 0, 0, 16);
    run(7, 0, 1, 2, 0, 0, 0, 0, 0);
    run(5, 3, 1, 0, 0, 0, 1, 0, 32'h55);
    run(6, 2, 2, 0, 0, 0, 1, 0, 32'h3);
    run(0, 0, 0, 0, 0, 0, 0, 0, 3);
    run(1, 0, 0, 0, 0, 0, 0, 0, 16);
    run(0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(1, 0, 0, 0, 0, 0, 0, 0, 16);
    run(0, 0, 0, 0, 0, 0, 0, 0, 1);
    run(2, 1, 0, 0, 0, 0, 0, 12, 32'hDEAD);
    run(2, 1, 0, 0, 0, 0, 0, 7, 32'hBEEF);
    run(3, 0, 1, 1, 0, 0, 1, 0, 0);

    for (int t = 0; t < 400; t++) begin
      int op = int'($urandom_range(0, 7));
      int va = int'($urandom_range(0, 3));
      int vb = ($urandom_range(0, 3) == 0) ? va : int'($urandom_range(0, 3));
      logic [31:0] s;
      if (op == 0) s = $urandom_range(0, 3);
      else if (op == 1) s = $urandom_range(0, 20);
      else s = $urandom;
      run(op, int'($urandom_range(0, 3)), va, vb, int'($urandom_range(0, 1)),
          int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), s);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule